// File: doc/BRIEF.md
# I2C Target with Register-Port Access

This block is a target on a two-wire serial bus. It lets a bus controller write and read a bank of up to 128 byte-wide registers that sit outside the block. The bus clock and data lines are brought into the system clock domain through synchronizer flops and are oversampled there. The data line is driven open-drain: the block only ever asks for the line to be pulled low.

After a START condition the block takes in an address byte. Its upper seven bits must equal `0b001100s`, where `s` is the level on a strap pin, and its lowest bit gives the transfer direction. In write direction the next byte is a sub-address. Its low seven bits load the register pointer and its top bit turns on pointer auto-increment. The data bytes that follow are handed to the register port one write strobe per byte. A read is made from a write-direction address and sub-address, then a repeated START, then the address in read direction. The block then shifts out register bytes until the controller answers with a NACK.

The register port is combinational on the read side. `reg_addr_o` always shows the current pointer, and the attached bank must return `reg_rdata_i` for that address in the same cycle.

Top module: `i2c_regport_target`

## Requirements
- R1: A falling data line while the clock line is high (START, also repeated START) restarts address reception from any state. A rising data line while the clock is high (STOP) returns the block to idle with the data line released. A write that is cut short by either of these before its eighth data bit issues no register write.
- R2: The target reacts only when the seven upper bits of the first byte after START equal `{6'b001100, addr_strap_i}`. Bit 0 is the direction, 1 for read. On a mismatch it gives no ACK and ignores the bus until the next START.
- R3: After each byte it receives (the address byte, the sub-address byte and every write data byte), the target holds the data line low for the high phase of the ninth clock.
- R4: Bits 6:0 of the sub-address byte load the register pointer and bit 7 sets the auto-increment flag. This holds even if the transfer then ends.
- R5: Each write data byte, received MSB first, gives exactly one single-cycle `reg_we_o` pulse, with `reg_wdata_o` equal to the byte and `reg_addr_o` equal to the pointer.
- R6: With auto-increment on, the pointer advances by one after each acknowledged write byte and after each read byte that the controller ACKs. It wraps from 127 to 0.
- R7: With auto-increment off, the pointer keeps its value over any number of data bytes in either direction.
- R8: In read direction the target sends `reg_rdata_i` at the current pointer, MSB first. It changes the data line only while the clock line is low and releases the line during the ninth clock so it can sample the controller's ACK.
- R9: A NACK from the controller ends the read. The data line stays released and no further data is driven until the next START.
- R10: After reset `sda_oe_o` and `reg_we_o` are 0 and `reg_addr_o` is 0. The block has no high drive for the data line; `sda_oe_o`=1 means pull low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times the bus clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls the data line low, 0 releases it |
| addr_strap_i | input | 1 | Selects bit 0 of the 7-bit device address |
| reg_addr_o | output | 7 | Register pointer, used for both write and read |
| reg_wdata_o | output | 8 | Byte to write |
| reg_we_o | output | 1 | One-cycle write strobe |
| reg_rdata_i | input | 8 | Register contents at `reg_addr_o`, same cycle |

## Verification
The hardest case to reach is a burst read in which the pointer crosses from 127 to 0. It needs a sub-address of 0xFE with the auto-increment bit set and a repeated START. The controller must then ACK two bytes and NACK the third, and the registers at both ends of the bank must already hold known values. The stimulus gets there in steps. A table-driven run of writes first places distinct values at 127 and at 0 through a wrapping burst write. A directed read sequence then walks across the boundary. After the NACK it keeps clocking the bus to show that the data line stays released. A second hard case is a STOP right after the sub-address. It is reached the same way, and a following read without a sub-address proves that the pointer was still loaded.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   localparam int BYTE_W = 8;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_SUB,
      ST_SUB_ACK,
      ST_WDATA,
      ST_WDATA_ACK,
      ST_RDATA,
      ST_RDATA_ACK
   } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
   parameter int       STAGES    = 2,
   parameter bit       RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("i2c_tgt_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= {STAGES{RESET_VAL}};
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i};
   end

   assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/i2c_tgt_busmon.sv
module i2c_tgt_busmon (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s_i,
   input  logic sda_s_i,
   output logic scl_rise_o,
   output logic scl_fall_o,
   output logic start_o,
   output logic stop_o
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s_i;
         sda_q <= sda_s_i;
      end
   end

   assign scl_rise_o = scl_s_i & ~scl_q;
   assign scl_fall_o = ~scl_s_i & scl_q;
   assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
   assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
   parameter int PTR_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [PTR_W-1:0] load_ptr_i,
   input  logic             load_auto_i,
   input  logic             step_i,
   output logic [PTR_W-1:0] ptr_o,
   output logic             auto_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_o  <= '0;
         auto_o <= 1'b0;
      end else if (load_i) begin
         ptr_o  <= load_ptr_i;
         auto_o <= load_auto_i;
      end else if (step_i && auto_o) begin
         ptr_o  <= ptr_o + 1'b1;
      end
   end
endmodule

// File: rtl/i2c_regport_target.sv
module i2c_regport_target
   import i2c_tgt_pkg::*;
#(
   parameter logic [5:0] DEV_ADDR_HI = 6'b001100,
   parameter int         SYNC_STAGES = 2,
   parameter int         PTR_W       = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             scl_i,
   input  logic             sda_i,
   output logic             sda_oe_o,
   input  logic             addr_strap_i,
   output logic [PTR_W-1:0] reg_addr_o,
   output logic [7:0]       reg_wdata_o,
   output logic             reg_we_o,
   input  logic [7:0]       reg_rdata_i
);
   localparam int CNT_W = $clog2(BYTE_W + 1);
   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(BYTE_W);

   generate
      if (PTR_W < 1 || PTR_W > BYTE_W - 1) begin : g_bad_ptr
         $error("i2c_regport_target: PTR_W must be 1..7");
      end
   endgenerate

   logic scl_s, sda_s;
   logic scl_rise, scl_fall, start_det, stop_det;

   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_scl (
      .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s));
   i2c_tgt_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync_sda (
      .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s));

   i2c_tgt_busmon u_busmon (
      .clk(clk), .rst_n(rst_n), .scl_s_i(scl_s), .sda_s_i(sda_s),
      .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
      .start_o(start_det), .stop_o(stop_det));

   tgt_state_e          state_q;
   logic [BYTE_W-1:0]   shreg_q, tx_q;
   logic [CNT_W-1:0]    cnt_q;
   logic                rw_q, mack_q, oe_q, we_q;
   logic [BYTE_W-1:0]   wdata_q;
   logic [6:0]          own_addr;

   logic                ptr_load, ptr_step, ptr_auto;
   logic [PTR_W-1:0]    ptr;

   assign own_addr = {DEV_ADDR_HI, addr_strap_i};

   always_comb begin
      ptr_load = (state_q == ST_SUB) && scl_fall && (cnt_q == LAST_CNT)
                 && !start_det && !stop_det;
      ptr_step = ((state_q == ST_WDATA_ACK) && scl_fall) ||
                 ((state_q == ST_RDATA_ACK) && scl_rise && !sda_s);
   end

   i2c_tgt_ptr #(.PTR_W(PTR_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load_i(ptr_load), .load_ptr_i(shreg_q[PTR_W-1:0]),
      .load_auto_i(shreg_q[BYTE_W-1]), .step_i(ptr_step),
      .ptr_o(ptr), .auto_o(ptr_auto));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         shreg_q <= '0;
         tx_q    <= '0;
         cnt_q   <= '0;
         rw_q    <= 1'b0;
         mack_q  <= 1'b0;
         oe_q    <= 1'b0;
         we_q    <= 1'b0;
         wdata_q <= '0;
      end else begin
         we_q <= 1'b0;
         if (start_det) begin
            state_q <= ST_ADDR;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else if (stop_det) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            oe_q    <= 1'b0;
         end else begin
            unique case (state_q)
               ST_IDLE: ;
               ST_ADDR, ST_SUB, ST_WDATA: begin
                  if (scl_rise && cnt_q != LAST_CNT) begin
                     shreg_q <= {shreg_q[BYTE_W-2:0], sda_s};
                     cnt_q   <= cnt_q + 1'b1;
                  end else if (scl_fall && cnt_q == LAST_CNT) begin
                     cnt_q <= '0;
                     if (state_q == ST_ADDR) begin
                        if (shreg_q[BYTE_W-1:1] == own_addr) begin
                           rw_q    <= shreg_q[0];
                           oe_q    <= 1'b1;
                           state_q <= ST_ADDR_ACK;
                        end else begin
                           state_q <= ST_IDLE;
                        end
                     end else if (state_q == ST_SUB) begin
                        oe_q    <= 1'b1;
                        state_q <= ST_SUB_ACK;
                     end else begin
                        oe_q    <= 1'b1;
                        we_q    <= 1'b1;
                        wdata_q <= shreg_q;
                        state_q <= ST_WDATA_ACK;
                     end
                  end
               end
               ST_ADDR_ACK: begin
                  if (scl_fall) begin
                     if (rw_q) begin
                        tx_q    <= reg_rdata_i;
                        oe_q    <= ~reg_rdata_i[BYTE_W-1];
                        state_q <= ST_RDATA;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_SUB;
                     end
                  end
               end
               ST_SUB_ACK, ST_WDATA_ACK: begin
                  if (scl_fall) begin
                     oe_q    <= 1'b0;
                     state_q <= ST_WDATA;
                  end
               end
               ST_RDATA: begin
                  if (scl_rise && cnt_q != LAST_CNT) begin
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt_q == LAST_CNT) begin
                        oe_q    <= 1'b0;
                        cnt_q   <= '0;
                        state_q <= ST_RDATA_ACK;
                     end else begin
                        tx_q <= {tx_q[BYTE_W-2:0], 1'b0};
                        oe_q <= ~tx_q[BYTE_W-2];
                     end
                  end
               end
               ST_RDATA_ACK: begin
                  if (scl_rise) begin
                     mack_q <= ~sda_s;
                  end else if (scl_fall) begin
                     if (mack_q) begin
                        tx_q    <= reg_rdata_i;
                        oe_q    <= ~reg_rdata_i[BYTE_W-1];
                        state_q <= ST_RDATA;
                     end else begin
                        oe_q    <= 1'b0;
                        state_q <= ST_IDLE;
                     end
                  end
               end
               default: state_q <= ST_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o    = oe_q;
   assign reg_we_o    = we_q;
   assign reg_wdata_o = wdata_q;
   assign reg_addr_o  = ptr;
endmodule

// File: rtl/i2c_regport_target_chk.sv
module i2c_regport_target_chk
   import i2c_tgt_pkg::*;
#(
   parameter int PTR_W = 7
) (
   input logic             clk,
   input logic             rst_n,
   input tgt_state_e       state,
   input logic             sda_oe,
   input logic             scl_s,
   input logic             reg_we,
   input logic             start_det,
   input logic             stop_det,
   input logic             ptr_step,
   input logic             ptr_auto,
   input logic [PTR_W-1:0] ptr
);
   assert_start_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> state == ST_ADDR);

   assert_stop_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (state == ST_IDLE && !sda_oe));

   assert_ack_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_ADDR_ACK || state == ST_SUB_ACK || state == ST_WDATA_ACK) |-> sda_oe);

   assert_we_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);

   assert_we_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |-> state == ST_WDATA_ACK);

   assert_ptr_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_step && ptr_auto && ptr == {PTR_W{1'b1}}) |=> ptr == '0);

   assert_ptr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_step && !ptr_auto) |=> $stable(ptr));

   assert_oe_scl_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_oe) |-> !scl_s);

   assert_idle_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
      state == ST_IDLE |-> !sda_oe);
endmodule

bind i2c_regport_target i2c_regport_target_chk #(.PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .state(state_q), .sda_oe(oe_q), .scl_s(scl_s),
   .reg_we(we_q), .start_det(start_det), .stop_det(stop_det),
   .ptr_step(ptr_step), .ptr_auto(ptr_auto), .ptr(ptr));

// File: tb/i2c_regport_target_tb_top.sv
`timescale 1ns/1ps
module i2c_regport_target_tb_top;
   localparam int H = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1, strap = 1'b0;
   logic sda_oe, reg_we;
   logic [6:0] reg_addr;
   logic [7:0] reg_wdata, reg_rdata;
   wire  sda_line = sda_m & ~sda_oe;

   logic [7:0] regs [128];
   int we_count = 0;
   int oe_viol = 0;
   logic oe_prev = 1'b0;
   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   function automatic logic [7:0] init_val(int i);
      return 8'(i * 7 + 3);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 128; i++) regs[i] <= init_val(i);
      end else if (reg_we) begin
         regs[reg_addr] <= reg_wdata;
         we_count <= we_count + 1;
      end
      oe_prev <= sda_oe;
      if (rst_n && scl_m && (sda_oe != oe_prev)) oe_viol <= oe_viol + 1;
   end
   assign reg_rdata = regs[reg_addr];

   i2c_regport_target dut_i (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .sda_oe_o(sda_oe), .addr_strap_i(strap), .reg_addr_o(reg_addr),
      .reg_wdata_o(reg_wdata), .reg_we_o(reg_we), .reg_rdata_i(reg_rdata));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic bit_io(input logic b, output logic s);
      wait_cyc(H/2); sda_m = b;
      wait_cyc(H/2); scl_m = 1'b1;
      wait_cyc(H/2); s = sda_line;
      wait_cyc(H/2); scl_m = 1'b0;
   endtask

   task automatic bus_start();
      wait_cyc(H/2); sda_m = 1'b1;
      wait_cyc(H/2); scl_m = 1'b1;
      wait_cyc(H);   sda_m = 1'b0;
      wait_cyc(H);   scl_m = 1'b0;
   endtask

   task automatic bus_stop();
      wait_cyc(H/2); sda_m = 1'b0;
      wait_cyc(H/2); scl_m = 1'b1;
      wait_cyc(H);   sda_m = 1'b1;
      wait_cyc(H);
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) bit_io(b[i], s);
      bit_io(1'b1, s);
      ack = !s;
   endtask

   task automatic recv_byte(input logic give_ack, output logic [7:0] b);
      logic s;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         bit_io(1'b1, s);
         b = {b[6:0], s};
      end
      bit_io(!give_ack, s);
   endtask

   // {address byte, sub-address, data0, data1, expected ACK}
   localparam logic [32:0] VEC [6] = '{
      {8'h30, 8'h85, 8'h11, 8'h22, 1'b1},
      {8'h30, 8'h10, 8'h33, 8'h44, 1'b1},
      {8'h32, 8'h20, 8'h55, 8'h66, 1'b0},
      {8'h30, 8'hFF, 8'h77, 8'h88, 1'b1},
      {8'h3C, 8'h40, 8'h99, 8'hAA, 1'b0},
      {8'h30, 8'hC0, 8'hBB, 8'hCC, 1'b1}
   };

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic ack;
      logic [7:0] rb;
      int wc0;
      wait_cyc(5);
      // R10: reset state
      chk("R10", "sda_oe after reset", int'(sda_oe), 0);
      chk("R10", "reg_we after reset", int'(reg_we), 0);
      chk("R10", "reg_addr after reset", int'(reg_addr), 0);
      rst_n = 1'b1;
      wait_cyc(5);

      for (int v = 0; v < 6; v++) begin
         logic [7:0] ab, sb, d0, d1;
         logic ea;
         logic [6:0] p;
         {ab, sb, d0, d1, ea} = VEC[v];
         p = sb[6:0];
         wc0 = we_count;
         bus_start();
         send_byte(ab, ack);
         chk("R2", $sformatf("vec%0d address ack", v), int'(ack), int'(ea));
         if (ea) begin
            send_byte(sb, ack);
            chk("R3", $sformatf("vec%0d sub ack", v), int'(ack), 1);
            send_byte(d0, ack);
            chk("R3", $sformatf("vec%0d data0 ack", v), int'(ack), 1);
            send_byte(d1, ack);
            chk("R3", $sformatf("vec%0d data1 ack", v), int'(ack), 1);
            bus_stop();
            wait_cyc(4);
            chk("R5", $sformatf("vec%0d strobes", v), we_count - wc0, 2);
            if (sb[7]) begin
               chk("R6", $sformatf("vec%0d first reg", v), int'(regs[p]), int'(d0));
               chk("R6", $sformatf("vec%0d second reg", v), int'(regs[7'(p + 7'd1)]), int'(d1));
               chk("R6", $sformatf("vec%0d pointer", v), int'(reg_addr), int'(7'(p + 7'd2)));
            end else begin
               chk("R7", $sformatf("vec%0d reg", v), int'(regs[p]), int'(d1));
               chk("R7", $sformatf("vec%0d next reg untouched", v),
                   int'(regs[7'(p + 7'd1)]), int'(init_val(int'(7'(p + 7'd1)))));
               chk("R4", $sformatf("vec%0d pointer held", v), int'(reg_addr), int'(p));
            end
         end else begin
            send_byte(sb, ack);
            chk("R2", $sformatf("vec%0d ignored after mismatch", v), int'(ack), 0);
            bus_stop();
            wait_cyc(4);
            chk("R2", $sformatf("vec%0d no strobe", v), we_count - wc0, 0);
         end
      end

      // R2: strap moves the address
      strap = 1'b1;
      wait_cyc(4);
      bus_start(); send_byte(8'h30, ack);
      chk("R2", "strap=1 rejects 0x30", int'(ack), 0);
      bus_stop();
      bus_start(); send_byte(8'h32, ack);
      chk("R2", "strap=1 accepts 0x32", int'(ack), 1);
      send_byte(8'h05, ack); send_byte(8'hE1, ack); bus_stop();
      wait_cyc(4);
      chk("R5", "strap write value", int'(regs[5]), 8'hE1);
      strap = 1'b0;
      wait_cyc(4);

      // R8/R6: burst read across 127 -> 0, then R9 release
      bus_start(); send_byte(8'h30, ack); send_byte(8'hFE, ack);
      bus_start(); send_byte(8'h31, ack);
      chk("R8", "read address ack", int'(ack), 1);
      recv_byte(1'b1, rb); chk("R8", "read reg 7E", int'(rb), int'(init_val(126)));
      recv_byte(1'b1, rb); chk("R6", "read reg 7F", int'(rb), 8'h77);
      recv_byte(1'b0, rb); chk("R6", "read wrapped reg 00", int'(rb), 8'h88);
      wc0 = we_count;
      recv_byte(1'b1, rb);
      chk("R9", "bus released after NACK", int'(rb), 8'hFF);
      chk("R9", "no drive after NACK", int'(sda_oe), 0);
      bus_stop();
      chk("R9", "no strobe after NACK", we_count - wc0, 0);

      // R7: read with auto-increment off repeats one register
      bus_start(); send_byte(8'h30, ack); send_byte(8'h05, ack);
      bus_start(); send_byte(8'h31, ack);
      recv_byte(1'b1, rb); chk("R7", "no-inc read 1", int'(rb), 8'hE1);
      recv_byte(1'b0, rb); chk("R7", "no-inc read 2", int'(rb), 8'hE1);
      bus_stop();

      // R1/R4: STOP right after sub-address, pointer still loaded
      wc0 = we_count;
      bus_start(); send_byte(8'h30, ack); send_byte(8'h22, ack); bus_stop();
      chk("R1", "stop after sub no strobe", we_count - wc0, 0);
      chk("R1", "stop releases line", int'(sda_oe), 0);
      bus_start(); send_byte(8'h31, ack);
      recv_byte(1'b0, rb);
      chk("R4", "pointer from aborted write", int'(rb), int'(init_val(34)));
      bus_stop();

      // R1: repeated START after a data byte
      bus_start(); send_byte(8'h30, ack); send_byte(8'h85, ack); send_byte(8'h5A, ack);
      bus_start(); send_byte(8'h31, ack);
      chk("R1", "repeated start address ack", int'(ack), 1);
      recv_byte(1'b0, rb);
      chk("R1", "read after repeated start", int'(rb), 8'h22);
      bus_stop();
      chk("R5", "byte before repeated start", int'(regs[5]), 8'h5A);

      chk("R8", "line changes while clock high", oe_viol, 0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule